// File: doc/BRIEF.md
# Page Write Sequencer for a Serial EEPROM

This block sits behind the byte-level logic of a two-wire serial memory slave. When the slave has received a write control byte and a word address, it pulses a start strobe with that address. Each data byte that follows is parked in an eight-entry page buffer. The entry is chosen by the low three bits of a running offset. Only that offset advances, so a burst that crosses the end of the page wraps back to the page start. Bytes sent after the eighth overwrite the earlier ones in arrival order. A per-entry valid flag records which entries hold new data.

A commit request, issued when the slave sees a stop condition, starts a self-timed programming cycle. This happens only if at least one byte is buffered and the supply-low input is clear. The cycle lasts a parameterised number of clock cycles. During it, busy is high, and the slave uses busy to withhold every acknowledge. At the end of the cycle, the valid entries are copied into a 256 x 8 register array and the flags are cleared. An abort request, issued on a repeated start, throws the buffer away without programming. The address pointer used by later current-address reads is kept and exposed. A read port gives access to the array contents.

Top module: `page_write_sequencer`

## Requirements
- R1: After reset, busy is 0, the read pointer is 0 and every array byte reads 0.
- R2: A start strobe loads the read pointer with the given address, sets the page to its upper five bits and the offset to its lower three bits, and clears all valid flags. A second start before commit discards the bytes buffered so far.
- R3: Each data byte is buffered at array address {page, offset}. The offset then increments modulo 8 and the page never changes, so a burst started mid-page wraps to the page start.
- R4: When more than eight bytes arrive before commit, the byte received last for a given offset is the one written.
- R5: A commit request while at least one byte is buffered and supply-low is 0 raises busy from the next cycle, for exactly WRITE_CYCLES cycles.
- R6: Array contents do not change while busy is high. The buffered bytes appear in the array in the cycle in which busy falls.
- R7: Only entries with a set valid flag are written. The other bytes of the page keep their values, and all flags are clear after the cycle.
- R8: A commit request with no buffered byte (an address-only write) starts no cycle and leaves the array unchanged.
- R9: An abort request discards the buffer and starts no cycle, but keeps the read pointer. Data bytes arriving after it and before a new start are ignored.
- R10: A commit request while supply-low is 1 starts no cycle and discards the buffer.
- R11: While busy is high, start, data, commit and abort strobes are ignored. The read pointer and the array are unaffected by them.
- R12: After each buffered byte, the read pointer equals {page, (offset + 1) mod 8}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrStart | input | 1 | One-cycle pulse: word address received for a write |
| wrAddr | input | 8 | Word address accompanying wrStart |
| byteStb | input | 1 | One-cycle pulse: data byte received |
| byteData | input | 8 | Data byte accompanying byteStb |
| commitReq | input | 1 | One-cycle pulse: stop condition seen |
| abortReq | input | 1 | One-cycle pulse: repeated start seen |
| supplyLow | input | 1 | Supply-low indication; blocks commits |
| busy | output | 1 | Programming cycle in progress; acknowledges must be withheld |
| rdPtr | output | 8 | Address pointer for current-address reads |
| rdAddr | input | 8 | Array read address |
| rdData | output | 8 | Array byte at rdAddr (combinational) |

## Verification
The properties assume that every strobe is a single-cycle pulse, and that supply-low is valid in the cycle the commit request is sampled. The control logic settles simultaneous strobes by a fixed priority: abort first, then commit, then start, then data. The bench never overlaps strobes outside the busy window. It drives each pulse for one cycle on the falling clock edge and holds supply-low only around its own commit. Inside a programming cycle it deliberately fires start, data and abort strobes to show that they are dropped. Randomised transactions vary the start offset, the burst length (0 to 12 bytes) and the way each transaction ends.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

  // Strobes from the sequencer control to the page datapath
  typedef struct packed {
    logic loadAddr;     // take new page/offset, clear flags
    logic storeByte;    // park byteData at current offset
    logic clearBuf;     // drop all buffered entries
    logic commitWrite;  // copy flagged entries into the array
  } pgwStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_BURN    = 2'd2
  } pgwState_t;

endpackage

// File: rtl/pgw_ctrl.sv
module pgw_ctrl
  import pgw_pkg::*;
#(
  parameter int WRITE_CYCLES = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrStart,
  input  logic       byteStb,
  input  logic       commitReq,
  input  logic       abortReq,
  input  logic       supplyLow,
  input  logic       anyValid,
  output pgwStrobe_t strobe,
  output logic       busy
);

  localparam int CNT_W = $clog2(WRITE_CYCLES + 1);

  pgwState_t         state, nextState;
  logic [CNT_W-1:0]  cnt;

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (wrStart) begin
          strobe.loadAddr = 1'b1;
          nextState       = ST_COLLECT;
        end
      end
      ST_COLLECT: begin
        if (abortReq) begin
          strobe.clearBuf = 1'b1;
          nextState       = ST_IDLE;
        end else if (commitReq) begin
          if (anyValid && !supplyLow) begin
            nextState = ST_BURN;
          end else begin
            strobe.clearBuf = 1'b1;
            nextState       = ST_IDLE;
          end
        end else if (wrStart) begin
          strobe.loadAddr = 1'b1;
        end else if (byteStb) begin
          strobe.storeByte = 1'b1;
        end
      end
      ST_BURN: begin
        if (cnt == CNT_W'(1)) begin
          strobe.commitWrite = 1'b1;
          nextState          = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      if (state == ST_COLLECT && nextState == ST_BURN)
        cnt <= CNT_W'(WRITE_CYCLES);
      else if (state == ST_BURN)
        cnt <= cnt - CNT_W'(1);
    end
  end

  assign busy = (state == ST_BURN);

  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(commitReq && anyValid && !supplyLow));

  // R5
  busy_length_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(cnt) == CNT_W'(1)));

  // R8
  empty_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && commitReq && !anyValid) |=> !busy);

  // R10
  low_supply_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && commitReq && supplyLow) |=> !busy);

endmodule

// File: rtl/pgw_datapath.sv
module pgw_datapath
  import pgw_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  pgwStrobe_t        strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] byteData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] rdPtr,
  output logic              anyValid
);

  localparam int PAGE_BYTES = 1 << PAGE_BITS;
  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_ID_W  = ADDR_W - PAGE_BITS;

  logic [PAGE_ID_W-1:0]  pageId;
  logic [PAGE_BITS-1:0]  offset;
  logic [ADDR_W-1:0]     ptrQ;
  logic [DATA_W-1:0]     bufQ   [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] validQ;
  logic [DATA_W-1:0]     mem    [DEPTH];

  // Page number, running offset and read pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageId <= '0;
      offset <= '0;
      ptrQ   <= '0;
    end else if (strobe.loadAddr) begin
      pageId <= wrAddr[ADDR_W-1:PAGE_BITS];
      offset <= wrAddr[PAGE_BITS-1:0];
      ptrQ   <= wrAddr;
    end else if (strobe.storeByte) begin
      offset <= offset + PAGE_BITS'(1);
      ptrQ   <= {pageId, offset + PAGE_BITS'(1)};
    end
  end

  // One lane per page byte: data latch plus valid flag
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : gLane
    logic hit;
    assign hit = strobe.storeByte && (offset == PAGE_BITS'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bufQ[g]   <= '0;
        validQ[g] <= 1'b0;
      end else begin
        if (hit)
          bufQ[g] <= byteData;
        if (strobe.loadAddr || strobe.clearBuf || strobe.commitWrite)
          validQ[g] <= 1'b0;
        else if (hit)
          validQ[g] <= 1'b1;
      end
    end
  end

  // Register array, written only at the end of a programming cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int a = 0; a < DEPTH; a++)
        mem[a] <= '0;
    end else if (strobe.commitWrite) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        if (validQ[i])
          mem[{pageId, PAGE_BITS'(i)}] <= bufQ[i];
    end
  end

  assign rdData   = mem[rdAddr];
  assign rdPtr    = ptrQ;
  assign anyValid = |validQ;

  // R3
  page_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeByte |=> $stable(pageId));

  // R3
  offset_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeByte |=> (offset == PAGE_BITS'($past(offset) + 1'b1)));

  // R7
  flags_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitWrite |=> (validQ == '0));

  // R12
  ptr_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.storeByte |=> (rdPtr == {pageId, offset}));

  // R2
  load_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadAddr |=> !anyValid);

endmodule

// File: rtl/page_write_sequencer.sv
module page_write_sequencer
  import pgw_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int PAGE_BITS    = 3,
  parameter int WRITE_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStart,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              byteStb,
  input  logic [DATA_W-1:0] byteData,
  input  logic              commitReq,
  input  logic              abortReq,
  input  logic              supplyLow,
  output logic              busy,
  output logic [ADDR_W-1:0] rdPtr,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  pgwStrobe_t strobe;
  logic       anyValid;

  pgw_ctrl #(
    .WRITE_CYCLES(WRITE_CYCLES)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrStart   (wrStart),
    .byteStb   (byteStb),
    .commitReq (commitReq),
    .abortReq  (abortReq),
    .supplyLow (supplyLow),
    .anyValid  (anyValid),
    .strobe    (strobe),
    .busy      (busy)
  );

  pgw_datapath #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PAGE_BITS (PAGE_BITS)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrAddr   (wrAddr),
    .byteData (byteData),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .rdPtr    (rdPtr),
    .anyValid (anyValid)
  );

endmodule

// File: tb/page_write_sequencer_test.sv
module page_write_sequencer_test;

  localparam int WC = 40;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrStart = 1'b0;
  logic [7:0] wrAddr = '0;
  logic       byteStb = 1'b0;
  logic [7:0] byteData = '0;
  logic       commitReq = 1'b0;
  logic       abortReq = 1'b0;
  logic       supplyLow = 1'b0;
  logic       busy;
  logic [7:0] rdPtr;
  logic [7:0] rdAddr = '0;
  logic [7:0] rdData;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model
  logic [7:0] mMem [256];
  logic [7:0] mBuf [8];
  logic [7:0] mVal;
  logic [4:0] mPage;
  logic [2:0] mOff;
  logic [7:0] mPtr;
  bit         mActive;

  always #4 clk = ~clk;

  page_write_sequencer #(.WRITE_CYCLES(WC)) uut (
    .clk(clk), .rstN(rstN), .wrStart(wrStart), .wrAddr(wrAddr),
    .byteStb(byteStb), .byteData(byteData), .commitReq(commitReq),
    .abortReq(abortReq), .supplyLow(supplyLow), .busy(busy),
    .rdPtr(rdPtr), .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] pageAddr(logic [4:0] p, int i);
    return {p, 3'(i)};
  endfunction

  task automatic readChk(string tag, logic [7:0] a, logic [7:0] exp);
    rdAddr = a;
    #1;
    chk(tag, rdData, exp);
  endtask

  task automatic checkPage(string tag, logic [4:0] p);
    for (int i = 0; i < 8; i++)
      readChk(tag, pageAddr(p, i), mMem[pageAddr(p, i)]);
  endtask

  task automatic startWrite(logic [7:0] a);
    wrStart = 1'b1; wrAddr = a;
    tick();
    wrStart = 1'b0;
    mPage = a[7:3]; mOff = a[2:0]; mVal = '0; mPtr = a; mActive = 1'b1;
    chk("R2 pointer load", rdPtr, a);
  endtask

  task automatic sendByte(logic [7:0] d);
    byteStb = 1'b1; byteData = d;
    tick();
    byteStb = 1'b0;
    if (mActive) begin
      mBuf[mOff] = d; mVal[mOff] = 1'b1;
      mOff = mOff + 3'd1;
      mPtr = {mPage, mOff};
    end
    chk("R12 pointer after byte", rdPtr, mPtr);
  endtask

  task automatic endAbort();
    abortReq = 1'b1;
    tick();
    abortReq = 1'b0;
    mVal = '0; mActive = 1'b0;
    chk("R9 no cycle after abort", busy, 0);
    chk("R9 pointer kept", rdPtr, mPtr);
  endtask

  task automatic endCommit(bit low);
    bit expCycle;
    int n;
    int firstIdx;
    expCycle = mActive && (mVal != 0) && !low;
    supplyLow = low; commitReq = 1'b1;
    tick();
    commitReq = 1'b0; supplyLow = 1'b0;
    if (low)
      chk("R10 supply low blocks cycle", busy, expCycle);
    else
      chk("R5 R8 busy after commit", busy, expCycle);
    if (expCycle) begin
      firstIdx = 0;
      for (int i = 7; i >= 0; i--) if (mVal[i]) firstIdx = i;
      n = 0;
      while (busy === 1'b1 && n < WC + 5) begin
        n++;
        if (n == 3) begin
          wrStart = 1'b1; wrAddr = 8'(($urandom % 256));
          byteStb = 1'b1; byteData = 8'hEE;
        end
        if (n == 4) begin
          wrStart = 1'b0; byteStb = 1'b0; commitReq = 1'b1; abortReq = 1'b1;
        end
        if (n == 5) begin
          commitReq = 1'b0; abortReq = 1'b0;
        end
        if (n == 6)
          readChk("R6 array held while busy", pageAddr(mPage, firstIdx),
                  mMem[pageAddr(mPage, firstIdx)]);
        tick();
      end
      chk("R5 busy length", n, WC);
      for (int i = 0; i < 8; i++)
        if (mVal[i]) mMem[pageAddr(mPage, i)] = mBuf[i];
      chk("R11 pointer unaffected while busy", rdPtr, mPtr);
      checkPage("R7 page contents after cycle", mPage);
    end else begin
      readChk("R8 R10 array unchanged", pageAddr(mPage, 0), mMem[pageAddr(mPage, 0)]);
    end
    mVal = '0; mActive = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int a = 0; a < 256; a++) mMem[a] = '0;
    mVal = '0; mPage = '0; mOff = '0; mPtr = '0; mActive = 1'b0;
    repeat (3) tick();
    #1;
    chk("R1 busy at reset", busy, 0);
    chk("R1 pointer at reset", rdPtr, 0);
    readChk("R1 array zero", 8'h00, 8'h00);
    readChk("R1 array zero", 8'hFF, 8'h00);
    rstN = 1'b1;
    tick();

    // R3 wrap inside page: start at offset 6, four bytes
    startWrite(8'h16);
    sendByte(8'hA1); sendByte(8'hA2); sendByte(8'hA3); sendByte(8'hA4);
    endCommit(1'b0);
    readChk("R3 wrapped byte", 8'h10, 8'hA3);
    readChk("R3 next page untouched", 8'h18, 8'h00);

    // R4 eleven bytes overwrite the oldest
    startWrite(8'h3D);
    for (int i = 0; i < 11; i++) sendByte(8'(8'h50 + i));
    endCommit(1'b0);
    readChk("R4 overwritten entry", 8'h3D, 8'h58);

    // R8 address-only write
    startWrite(8'h42);
    endCommit(1'b0);
    chk("R8 pointer set by address-only write", rdPtr, 8'h42);

    // R2 restart discards earlier bytes; R7 only flagged bytes written
    startWrite(8'h60);
    sendByte(8'h11);
    startWrite(8'h64);
    sendByte(8'h22);
    endCommit(1'b0);
    readChk("R2 discarded byte not written", 8'h60, 8'h00);
    readChk("R7 flagged byte written", 8'h64, 8'h22);

    // R9 abort then stray byte
    startWrite(8'h80);
    sendByte(8'h33);
    endAbort();
    sendByte(8'h44);
    readChk("R9 array untouched", 8'h80, 8'h00);

    // R10 supply low
    startWrite(8'h90);
    sendByte(8'h55);
    endCommit(1'b1);
    readChk("R10 array untouched", 8'h90, 8'h00);

    // random transactions
    for (int t = 0; t < 40; t++) begin
      int nb;
      int kind;
      startWrite(8'($urandom % 256));
      nb = $urandom % 13;
      for (int b = 0; b < nb; b++) sendByte(8'($urandom % 256));
      kind = $urandom % 10;
      if (kind == 0) endAbort();
      else endCommit(kind == 1);
      chk("R12 pointer after transaction", rdPtr, mPtr);
    end

    finishRun();
  end

endmodule